// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a memory burst. A controller pulses a start strobe together with the first column address, a burst-length code and an ordering select. From then on, each advance pulse steps the block to the next beat. The low bits of the address are reordered inside an aligned block whose size equals the burst length. The bits above that block stay at their starting value for the whole burst, so a burst never leaves its aligned block.

Two orderings are available:
- **Sequential:** counts up from the starting offset and wraps to zero at the block edge.
- **Interleaved:** forms each beat's offset as the starting offset XOR the beat number.

All outputs are registered. A start strobe sampled on a clock edge presents beat 0 right after that edge. A start that arrives during a burst abandons that burst and begins the new one. A length code outside the legal set runs as a two-beat burst and raises a configuration flag.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid_o`, `last_beat_o` and `cfg_illegal_o` are 0 and `col_addr_o` is 0.
- R2: A start sampled on a clock edge makes `beat_valid_o` 1 and `col_addr_o` equal to the start address after that edge.
- R3: With `interleave_i`=0, beat k of a burst of length L starting at offset s has in-block offset (s+k) mod L.
- R4: With `interleave_i`=1, beat k has in-block offset s XOR k.
- R5: During a burst, the address bits above the in-block offset (bit 1 and up for L=2, bit 2 and up for L=4, bit 3 and up for L=8) equal those of the start address.
- R6: `last_beat_o` is 1 exactly on beat L-1 of an active burst. An advance sampled on that beat clears `beat_valid_o` and `last_beat_o` and leaves `col_addr_o` unchanged.
- R7: An advance while no burst is active is ignored: `beat_valid_o` stays 0 and `col_addr_o` keeps its value.
- R8: A start during an active burst abandons it and restarts at beat 0 of the new address, length and ordering.
- R9: Length code 3'b001 selects 2 beats, 3'b010 selects 4 and 3'b011 selects 8. Any other code runs a 2-beat burst and sets `cfg_illegal_o`, which holds its value until the next start.
- R10: Without start or advance, all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst (priority over advance) |
| start_col_i | input | COL_W | First column address of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| advance_i | input | 1 | Step to the next beat |
| col_addr_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A burst beat is being presented |
| last_beat_o | output | 1 | Current beat is the final one |
| cfg_illegal_o | output | 1 | Last start used an unsupported length code |

## Verification
The bench targets several corner cases:
- **Sequential wrap at the block edge (start 5, length 8).** An adder that does not wrap would carry into bit 3 and break the upper-bit hold.
- **Interleaved start offsets.** A design that reused the sequential adder would produce 5-6-7-0 instead of 5-4-7-6.
- **A start in the middle of a burst.** A design that kept the old beat count would end the new burst too early.
- **Advances after the final beat and while idle.** A design that did not gate these would wander off the last address.
- **Illegal length codes.** A design that did not fall back to two beats would emit eight beats or a wrong last flag.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int OFF_W = 3;
  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [2:0] {
    LEN2 = 3'b001,
    LEN4 = 3'b010,
    LEN8 = 3'b011
  } len_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
(
  input  logic [2:0] code_i,
  output off_t       mask_o,
  output logic       illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    unique case (code_i)
      LEN2:    mask_o = 3'b001;
      LEN4:    mask_o = 3'b011;
      LEN8:    mask_o = 3'b111;
      default: begin
        mask_o    = 3'b001;
        illegal_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
  import burst_seq_pkg::*;
(
  input  off_t start_off_i,
  input  off_t beat_i,
  input  off_t mask_i,
  input  logic interleave_i,
  output off_t off_o
);
  off_t seq_off;
  off_t ilv_off;

  always_comb begin
    seq_off = off_t'(start_off_i + beat_i) & mask_i;
    ilv_off = (start_off_i ^ beat_i) & mask_i;
    off_o   = interleave_i ? ilv_off : seq_off;
  end
endmodule

// File: rtl/burst_addr_merge.sv
module burst_addr_merge
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  off_t             mask_i,
  input  off_t             off_i,
  output logic [COL_W-1:0] addr_o
);
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < OFF_W) begin : g_low
      assign addr_o[b] = mask_i[b] ? off_i[b] : base_i[b];
    end else begin : g_high
      assign addr_o[b] = base_i[b];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             advance_i,
  output logic [COL_W-1:0] col_addr_o,
  output logic             beat_valid_o,
  output logic             last_beat_o,
  output logic             cfg_illegal_o
);
  // burst state captured at start
  logic             act_q;
  off_t             idx_q;
  off_t             mask_q;
  off_t             off_q;
  logic             ilv_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] addr_q;
  logic             last_q;
  logic             ill_q;

  off_t             dec_mask;
  logic             dec_ill;
  off_t             sel_mask;
  off_t             sel_off;
  off_t             sel_idx;
  logic             sel_ilv;
  logic [COL_W-1:0] sel_base;
  off_t             calc_off;
  logic [COL_W-1:0] nxt_addr;
  off_t             idx_inc;
  logic             step;

  burst_len_decode u_dec (
    .code_i    (len_code_i),
    .mask_o    (dec_mask),
    .illegal_o (dec_ill)
  );

  assign idx_inc  = off_t'(idx_q + 3'd1);
  assign step     = advance_i & act_q;
  assign sel_mask = start_i ? dec_mask : mask_q;
  assign sel_off  = start_i ? start_col_i[OFF_W-1:0] : off_q;
  assign sel_idx  = start_i ? '0 : idx_inc;
  assign sel_ilv  = start_i ? interleave_i : ilv_q;
  assign sel_base = start_i ? start_col_i : base_q;

  burst_order_calc u_ord (
    .start_off_i  (sel_off),
    .beat_i       (sel_idx),
    .mask_i       (sel_mask),
    .interleave_i (sel_ilv),
    .off_o        (calc_off)
  );

  burst_addr_merge #(.COL_W(COL_W)) u_mrg (
    .base_i (sel_base),
    .mask_i (sel_mask),
    .off_i  (calc_off),
    .addr_o (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      mask_q <= 3'b001;
      off_q  <= '0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      addr_q <= '0;
      last_q <= 1'b0;
      ill_q  <= 1'b0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      idx_q  <= '0;
      mask_q <= dec_mask;
      off_q  <= start_col_i[OFF_W-1:0];
      ilv_q  <= interleave_i;
      base_q <= start_col_i;
      addr_q <= nxt_addr;
      last_q <= 1'b0;
      ill_q  <= dec_ill;
    end else if (step) begin
      if (last_q) begin
        act_q  <= 1'b0;
        last_q <= 1'b0;
      end else begin
        idx_q  <= idx_inc;
        addr_q <= nxt_addr;
        last_q <= (idx_inc == mask_q);
      end
    end
  end

  assign col_addr_o    = addr_q;
  assign beat_valid_o  = act_q;
  assign last_beat_o   = last_q;
  assign cfg_illegal_o = ill_q;

  // R2: start loads address exactly
  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (beat_valid_o && col_addr_o == $past(start_col_i)));

  // R5: bits above the block never move inside a burst
  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && !start_i) |=>
      (((col_addr_o ^ $past(col_addr_o)) & ~COL_W'(mask_q)) == '0));

  // R6: last only on valid beats, and advance on it ends the burst
  p_last_valid_r6: assert property (@(posedge clk) disable iff (rst)
    last_beat_o |-> beat_valid_o);
  p_last_end_r6: assert property (@(posedge clk) disable iff (rst)
    (last_beat_o && advance_i && !start_i) |=>
      (!beat_valid_o && $stable(col_addr_o)));

  // R7: idle stays idle without a start
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!beat_valid_o && !start_i) |=> (!beat_valid_o && $stable(col_addr_o)));

  // R9: unsupported code flags at the next edge
  p_illegal_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !(len_code_i inside {3'b001, 3'b010, 3'b011})) |=> cfg_illegal_o);

  // R10: outputs hold without stimulus
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !advance_i) |=>
      ($stable(col_addr_o) && $stable(beat_valid_o) &&
       $stable(last_beat_o) && $stable(cfg_illegal_o)));
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       len_code_i;
  logic             interleave_i;
  logic             advance_i;
  logic [COL_W-1:0] col_addr_o;
  logic             beat_valid_o;
  logic             last_beat_o;
  logic             cfg_illegal_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic             m_act;
  logic [COL_W-1:0] m_base;
  logic [COL_W-1:0] m_addr;
  int               m_len;
  int               m_k;
  logic             m_il;
  logic             m_ill;
  string            m_tag;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .advance_i(advance_i),
    .col_addr_o(col_addr_o), .beat_valid_o(beat_valid_o),
    .last_beat_o(last_beat_o), .cfg_illegal_o(cfg_illegal_o)
  );

  function automatic int len_of(logic [2:0] c);
    case (c)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      default: return 2;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] exp_addr(logic [COL_W-1:0] base, int len,
                                                logic il, int k);
    int s, o;
    s = int'(base) % len;
    o = il ? (s ^ k) : ((s + k) % len);
    return COL_W'((int'(base) / len) * len + o);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(m_tag, int'(col_addr_o), int'(m_addr));
    chk({m_tag, " valid"}, int'(beat_valid_o), int'(m_act));
    chk("R6 last", int'(last_beat_o), int'(m_act && m_k == m_len - 1));
    chk("R9 illegal flag", int'(cfg_illegal_o), int'(m_ill));
    if (m_act)
      chk("R5 upper bits", int'(col_addr_o) / m_len, int'(m_base) / m_len);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic st, logic [COL_W-1:0] col, logic [2:0] code,
                     logic il, logic adv);
    start_i = st; start_col_i = col; len_code_i = code;
    interleave_i = il; advance_i = adv;
    @(posedge clk);
    if (st) begin
      m_tag  = m_act ? "R8 restart" : "R2 start";
      m_act  = 1'b1; m_base = col; m_len = len_of(code); m_il = il;
      m_k    = 0; m_addr = col;
      m_ill  = !(code inside {3'b001, 3'b010, 3'b011});
    end else if (adv && m_act) begin
      if (m_k == m_len - 1) begin
        m_act = 1'b0; m_tag = "R6 end";
      end else begin
        m_k++;
        m_addr = exp_addr(m_base, m_len, m_il, m_k);
        m_tag  = m_il ? "R4 interleaved" : "R3 sequential";
      end
    end else if (adv) begin
      m_tag = "R7 idle advance";
    end else begin
      m_tag = "R10 hold";
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    rst = 1'b1; start_i = 0; start_col_i = '0; len_code_i = 3'b001;
    interleave_i = 0; advance_i = 0;
    m_act = 0; m_base = '0; m_addr = '0; m_len = 2; m_k = 0; m_il = 0;
    m_ill = 0; m_tag = "R1 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare();  // R1

    // R3 sequential wrap: 0x2D (offset 5) length 8 -> 5,6,7,0,1,2,3,4
    cyc(1, 10'h02D, 3'b011, 0, 0);
    repeat (8) cyc(0, '0, 3'b000, 0, 1);
    // R4 interleaved: offset 5 length 8 -> 5,4,7,6,1,0,3,2
    cyc(1, 10'h3FD, 3'b011, 1, 0);
    repeat (8) cyc(0, '0, 3'b000, 0, 1);
    // R7 idle advances
    repeat (3) cyc(0, '0, 3'b000, 0, 1);
    // R8 restart mid-burst
    cyc(1, 10'h106, 3'b010, 0, 1);
    cyc(0, '0, 3'b000, 0, 1);
    cyc(1, 10'h0F3, 3'b011, 1, 1);
    repeat (4) cyc(0, '0, 3'b000, 0, 1);
    // R9 illegal code runs two beats
    cyc(1, 10'h157, 3'b110, 0, 0);
    repeat (3) cyc(0, '0, 3'b000, 0, 1);
    cyc(1, 10'h001, 3'b001, 1, 0);
    // R10 hold
    repeat (2) cyc(0, '0, 3'b000, 0, 0);
    repeat (2) cyc(0, '0, 3'b000, 0, 1);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic       st, il, adv;
      logic [2:0] code;
      st   = ($urandom_range(0, 5) == 0);
      adv  = ($urandom_range(0, 2) != 0);
      il   = $urandom_range(0, 1);
      code = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 7))
                                         : 3'($urandom_range(1, 3));
      cyc(st, COL_W'($urandom), code, il, adv);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule